// File: doc/BRIEF.md
# Bank Capacity Resize Controller

This controller sits beside one bank of a shared cache whose capacity can be doubled up by switching in a slower, denser storage layer. It watches the bank's traffic over long fixed windows of cycles and decides, once per window, whether the bank should run in its small (fast-only) configuration or its large (fast plus dense) configuration. Every bank owns its own controller, so banks resize independently of each other.

Two independent metrics drive the decision. A high miss rate during the window asks the bank to grow. A low footprint during the window asks a large bank to shrink. The footprint is the number of distinct blocks touched in the window. The miss rate is compared without a divider: the bank grows when `misses << shift` is strictly greater than `threshold * accesses`. Footprint is kept as one touched flag per block plus a running count, and both are cleared at each window boundary. When the mode changes, the controller emits a one-cycle command pulse and holds a stall output for a fixed number of cycles to cover the flush.

Top module: `rsz_bank_resize`

## Requirements
- R1: While reset is held, and in the first window after it, the mode is small (`mode_o`=0), both command pulses are low and the stall output is low.
- R2: In small mode, when a window contains at least one access and `(misses << miss_shift_i) > miss_thr_i * accesses`, the mode becomes large (`mode_o`=1) and `grow_o` is high for exactly one cycle. That cycle is the one right after the last cycle of the window.
- R3: The miss-rate test is strict: when `misses << miss_shift_i` equals `miss_thr_i * accesses`, no grow happens.
- R4: In large mode, when a window contains at least one access and the number of distinct touched blocks is less than `use_thr_i`, the mode becomes small and `shrink_o` is high for exactly one cycle. That cycle is the one right after the window's last cycle.
- R5: Repeated touches of one block count as one. All touched flags clear at every window boundary, so blocks touched in an earlier window do not count toward the next one.
- R6: A window with zero accesses never changes the mode. A miss flag raised without an access is not counted.
- R7: Grow is considered only in small mode and shrink only in large mode. A low footprint in small mode, or a high miss rate in large mode, changes nothing.
- R8: After every mode change, `stall_o` is high for exactly `STALL_CYCLES` cycles, starting with the pulse cycle. It is low at all other times.
- R9: Events presented in the last cycle of a window count toward that window's decision.
- R10: The mode and the command pulses change only at a window boundary. A window is `INTERVAL_CYCLES` cycles long and is counted from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| access_i | input | 1 | One bank access this cycle |
| miss_i | input | 1 | The access this cycle missed (counted only with access_i) |
| touch_i | input | 1 | A block was referenced this cycle |
| touch_idx_i | input | IDX_W | Index of the referenced block |
| miss_shift_i | input | SHIFT_W | Left shift applied to the miss count |
| miss_thr_i | input | THR_W | Multiplier applied to the access count |
| use_thr_i | input | USE_W | Footprint below this value allows a shrink |
| mode_o | output | 1 | 0 = small configuration, 1 = large configuration |
| grow_o | output | 1 | One-cycle command to enable the extra capacity |
| shrink_o | output | 1 | One-cycle command to disable the extra capacity |
| stall_o | output | 1 | Requests to the bank must be held off |

## Verification
The hardest situation to reach is a shrink that depends on the touched flags having been cleared. The bank must first be grown, then see a window in which every block is touched, then see a window that touches just one block many times. The stimulus builds this in three directed windows before it moves on. It also steers windows into exact equality of the two sides of the miss test, and into events that arrive only in the final cycle. Randomized windows with varied thresholds, shift amounts and block spans then exercise both modes against a bench-side model of the counts.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
   typedef enum logic {
      BANK_SMALL = 1'b0,
      BANK_LARGE = 1'b1
   } bank_mode_e;
endpackage

// File: rtl/rsz_window_timer.sv
module rsz_window_timer #(
   parameter int unsigned INTERVAL_CYCLES = 10_000_000,
   localparam int unsigned TW = $clog2(INTERVAL_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   output logic last_o
);
   logic [TW-1:0] pos_q;

   assign last_o = (pos_q == TW'(INTERVAL_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      pos_q <= '0;
      else if (last_o) pos_q <= '0;
      else             pos_q <= pos_q + 1'b1;
   end
endmodule

// File: rtl/rsz_event_count.sv
module rsz_event_count #(
   parameter int unsigned CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          access_i,
   input  logic          miss_i,
   output logic [CW-1:0] acc_next_o,
   output logic [CW-1:0] miss_next_o
);
   logic [CW-1:0] acc_q, miss_q;

   always_comb begin
      acc_next_o  = acc_q  + CW'(access_i);
      miss_next_o = miss_q + CW'(access_i & miss_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         acc_q  <= '0;
         miss_q <= '0;
      end else begin
         acc_q  <= acc_next_o;
         miss_q <= miss_next_o;
      end
   end
endmodule

// File: rtl/rsz_touch_tracker.sv
module rsz_touch_tracker #(
   parameter int unsigned NUM_BLOCKS = 1024,
   localparam int unsigned IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
   localparam int unsigned USE_W = $clog2(NUM_BLOCKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             touch_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [USE_W-1:0] used_next_o
);
   logic [NUM_BLOCKS-1:0] seen_q;
   logic [NUM_BLOCKS-1:0] fresh;
   logic [USE_W-1:0]      used_q;

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      assign fresh[b] = touch_i && (idx_i == IDX_W'(b)) && !seen_q[b];
      always_ff @(posedge clk) begin
         if (!rst_n || clear_i) seen_q[b] <= 1'b0;
         else                   seen_q[b] <= seen_q[b] | fresh[b];
      end
   end

   assign used_next_o = used_q + USE_W'(|fresh);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) used_q <= '0;
      else                   used_q <= used_next_o;
   end
endmodule

// File: rtl/rsz_bank_resize.sv
module rsz_bank_resize
   import rsz_pkg::*;
#(
   parameter int unsigned INTERVAL_CYCLES = 10_000_000,
   parameter int unsigned STALL_CYCLES    = 100_000,
   parameter int unsigned NUM_BLOCKS      = 1024,
   parameter int unsigned SHIFT_W         = 3,
   parameter int unsigned THR_W           = 8,
   localparam int unsigned IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
   localparam int unsigned USE_W = $clog2(NUM_BLOCKS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               access_i,
   input  logic               miss_i,
   input  logic               touch_i,
   input  logic [IDX_W-1:0]   touch_idx_i,
   input  logic [SHIFT_W-1:0] miss_shift_i,
   input  logic [THR_W-1:0]   miss_thr_i,
   input  logic [USE_W-1:0]   use_thr_i,
   output logic               mode_o,
   output logic               grow_o,
   output logic               shrink_o,
   output logic               stall_o
);
   localparam int unsigned CNT_W = $clog2(INTERVAL_CYCLES + 1);
   localparam int unsigned CMP_W = CNT_W + THR_W + (1 << SHIFT_W);

   if (INTERVAL_CYCLES < 2) begin : g_bad_interval
      $error("rsz_bank_resize: INTERVAL_CYCLES must be at least 2");
   end
   if (STALL_CYCLES >= INTERVAL_CYCLES) begin : g_bad_stall
      $error("rsz_bank_resize: STALL_CYCLES must be below INTERVAL_CYCLES");
   end
   if (SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_shift
      $error("rsz_bank_resize: SHIFT_W must lie in 1..5");
   end

   logic             win_last;
   logic [CNT_W-1:0] acc_next, miss_next;
   logic [USE_W-1:0] used_next;
   logic [CMP_W-1:0] miss_side, acc_side;
   logic             grow_now, shrink_now;
   bank_mode_e       mode_q;

   rsz_window_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .last_o(win_last)
   );

   rsz_event_count #(.CW(CNT_W)) u_events (
      .clk(clk), .rst_n(rst_n), .clear_i(win_last),
      .access_i(access_i), .miss_i(miss_i),
      .acc_next_o(acc_next), .miss_next_o(miss_next)
   );

   rsz_touch_tracker #(.NUM_BLOCKS(NUM_BLOCKS)) u_touch (
      .clk(clk), .rst_n(rst_n), .clear_i(win_last),
      .touch_i(touch_i), .idx_i(touch_idx_i), .used_next_o(used_next)
   );

   always_comb begin
      miss_side  = CMP_W'(miss_next) << miss_shift_i;
      acc_side   = CMP_W'(acc_next) * CMP_W'(miss_thr_i);
      grow_now   = win_last && (mode_q == BANK_SMALL) && (acc_next != '0)
                   && (miss_side > acc_side);
      shrink_now = win_last && (mode_q == BANK_LARGE) && (acc_next != '0)
                   && (used_next < use_thr_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= BANK_SMALL;
         grow_o   <= 1'b0;
         shrink_o <= 1'b0;
      end else begin
         grow_o   <= grow_now;
         shrink_o <= shrink_now;
         if (grow_now)        mode_q <= BANK_LARGE;
         else if (shrink_now) mode_q <= BANK_SMALL;
      end
   end

   assign mode_o = mode_q;

   if (STALL_CYCLES > 0) begin : g_stall
      localparam int unsigned SW = $clog2(STALL_CYCLES + 1);
      logic [SW-1:0] left_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                    left_q <= '0;
         else if (grow_now | shrink_now) left_q <= SW'(STALL_CYCLES);
         else if (left_q != '0)         left_q <= left_q - 1'b1;
      end
      assign stall_o = (left_q != '0);
   end else begin : g_no_stall
      assign stall_o = 1'b0;
   end
endmodule

// File: rtl/rsz_bank_resize_checks.sv
module rsz_bank_resize_checks #(
   parameter int unsigned STALL_CYCLES = 100_000
) (
   input logic clk,
   input logic rst_n,
   input logic mode_o,
   input logic grow_o,
   input logic shrink_o,
   input logic stall_o
);
   a_r2_grow_single: assert property (@(posedge clk) disable iff (!rst_n)
      grow_o |=> !grow_o);

   a_r4_shrink_single: assert property (@(posedge clk) disable iff (!rst_n)
      shrink_o |=> !shrink_o);

   a_r7_grow_from_small: assert property (@(posedge clk) disable iff (!rst_n)
      grow_o |-> (mode_o && !$past(mode_o)));

   a_r7_shrink_from_large: assert property (@(posedge clk) disable iff (!rst_n)
      shrink_o |-> (!mode_o && $past(mode_o)));

   a_r10_mode_moves_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> (grow_o || shrink_o));

   a_r10_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grow_o, shrink_o}));

   if (STALL_CYCLES > 0) begin : g_stall_chk
      a_r8_cmd_stalls: assert property (@(posedge clk) disable iff (!rst_n)
         (grow_o || shrink_o) |-> stall_o);
   end
endmodule

bind rsz_bank_resize rsz_bank_resize_checks #(.STALL_CYCLES(STALL_CYCLES)) u_checks (
   .clk(clk), .rst_n(rst_n), .mode_o(mode_o),
   .grow_o(grow_o), .shrink_o(shrink_o), .stall_o(stall_o)
);

// File: tb/rsz_bank_resize_bench.sv
`timescale 1ns/1ps
module rsz_bank_resize_bench;
   localparam int INTERVAL = 64;
   localparam int STALL    = 20;
   localparam int NBLK     = 16;
   localparam int SHW      = 3;
   localparam int THW      = 8;
   localparam int IDX_W    = 4;
   localparam int USE_W    = 5;

   logic clk = 0, rst_n = 0;
   logic access_i = 0, miss_i = 0, touch_i = 0;
   logic [IDX_W-1:0] touch_idx_i = '0;
   logic [SHW-1:0]   miss_shift_i = '0;
   logic [THW-1:0]   miss_thr_i = '0;
   logic [USE_W-1:0] use_thr_i = '0;
   logic mode_o, grow_o, shrink_o, stall_o;

   int checks = 0, errors = 0;
   bit tb_mode = 0, prev_chg = 0;
   int nmiss = 0, missq = 0, span = 1;

   always #2.5 clk = ~clk;

   rsz_bank_resize #(
      .INTERVAL_CYCLES(INTERVAL), .STALL_CYCLES(STALL), .NUM_BLOCKS(NBLK),
      .SHIFT_W(SHW), .THR_W(THW)
   ) u_rsz_bank_resize (
      .clk(clk), .rst_n(rst_n), .access_i(access_i), .miss_i(miss_i),
      .touch_i(touch_i), .touch_idx_i(touch_idx_i), .miss_shift_i(miss_shift_i),
      .miss_thr_i(miss_thr_i), .use_thr_i(use_thr_i), .mode_o(mode_o),
      .grow_o(grow_o), .shrink_o(shrink_o), .stall_o(stall_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit want_grow(bit md, int acc, int mis, int k, int thr);
      return !md && acc > 0 && (longint'(mis) << k) > longint'(thr) * acc;
   endfunction

   function automatic bit want_shrink(bit md, int acc, int used, int uthr);
      return md && acc > 0 && used < uthr;
   endfunction

   // kind: 0 random, 1 misses without access, 2 nmiss of 8 accesses,
   // 3 touch every block, 4 one block touched ten times, 5 last cycle only
   task automatic run_interval(input int kind, input string tag);
      int acc = 0, mis = 0, used = 0, stl = 0, spur = 0, ix;
      bit seen[NBLK];
      bit a, m, t, eg, es;
      for (int b = 0; b < NBLK; b++) seen[b] = 0;
      for (int i = 0; i < INTERVAL; i++) begin
         if (stall_o) stl++;
         if (i > 0 && (grow_o || shrink_o)) spur++;
         a = 0; m = 0; t = 0; ix = 0;
         if (!stall_o) begin
            case (kind)
               0: begin
                  a = 1'($urandom % 2); m = ($urandom % 4) < missq;
                  t = 1'($urandom % 2); ix = $urandom % span;
               end
               1: m = 1;
               2: if (i >= 30 && i < 38) begin a = 1; m = (i < 30 + nmiss); end
               3: if (i >= 30 && i < 30 + NBLK) begin a = 1; m = 1; t = 1; ix = i - 30; end
               4: if (i >= 30 && i < 40) begin a = 1; t = 1; ix = 3; end
               5: if (i == INTERVAL - 1) begin a = 1; m = 1; end
               default: ;
            endcase
         end
         access_i = a; miss_i = m; touch_i = t; touch_idx_i = IDX_W'(ix);
         if (a) acc++;
         if (a && m) mis++;
         if (t && !seen[ix]) begin seen[ix] = 1; used++; end
         @(posedge clk); @(negedge clk);
      end
      access_i = 0; miss_i = 0; touch_i = 0;
      eg = want_grow(tb_mode, acc, mis, int'(miss_shift_i), int'(miss_thr_i));
      es = want_shrink(tb_mode, acc, used, int'(use_thr_i));
      check({tag, " R8 stall length"}, stl, prev_chg ? STALL : 0);
      check({tag, " R10 no mid-window command"}, spur, 0);
      check({tag, " grow_o"}, grow_o, eg);
      check({tag, " shrink_o"}, shrink_o, es);
      if (eg) tb_mode = 1;
      if (es) tb_mode = 0;
      check({tag, " mode_o"}, mode_o, tb_mode);
      prev_chg = eg | es;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion", 200000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset mode", mode_o, 0);
      check("R1 reset stall", stall_o, 0);
      check("R1 reset cmds", grow_o | shrink_o, 0);
      rst_n = 1;

      miss_shift_i = 0; miss_thr_i = 0; use_thr_i = 2;
      run_interval(1, "R6 zero accesses");
      miss_shift_i = 2; miss_thr_i = 1; nmiss = 2;
      run_interval(2, "R3 equal sides");
      nmiss = 3;
      run_interval(2, "R2 grow");
      use_thr_i = 4;
      run_interval(3, "R7 large ignores misses");
      use_thr_i = 2;
      run_interval(4, "R5 R4 shrink after clear");
      run_interval(4, "R7 small ignores usage");
      miss_shift_i = 0; miss_thr_i = 0;
      run_interval(5, "R9 last cycle");

      for (int n = 0; n < 40; n++) begin
         miss_shift_i = SHW'($urandom % 4);
         miss_thr_i   = THW'($urandom % 16);
         use_thr_i    = USE_W'($urandom % 17);
         missq        = $urandom % 5;
         span         = 1 + $urandom % NBLK;
         run_interval(0, "R2 R4 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule